// File: doc/BRIEF.md
# Serial Flash Custom-Instruction Sequencer

This block sits inside a serial flash controller and sends one free-form command to the attached device. Software loads the outgoing payload into two 32-bit data words. It then writes a configuration word that holds an opcode and a byte count. That write is the only trigger. The sequencer lowers chip select and clocks out the opcode and the payload on IO0, most significant bit first. While doing so it collects the device's answer from IO1. When the transfer ends, the answer sits in the same two data words that held the payload.

The transfer always runs as a plain one-line SPI exchange in mode 0. This holds even when the surrounding controller normally runs four data lines. The serial clock comes from the system clock through an even divider that software sets. While a transfer runs, the block reports itself busy and refuses register writes. At the end it gives a one-cycle completion pulse and sets a sticky ready flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write to address 2 while idle starts a transfer. In the next cycle `busy` is high and `cs_n` is low.
- R2: Bits [11:8] of the configuration word give the total byte count, opcode included. Values 1 to 9 are used as written, and 0 or any value above 9 counts as 1. Exactly 8 rising `sck` edges occur per byte.
- R3: The opcode (bits [7:0] of the configuration word) goes out first, then the payload bytes in ascending index. Every byte is sent most significant bit first on `io_out[0]`. `sck` idles low, and `io_out[0]` never changes while `sck` is high.
- R4: Response bits are taken only from `io_in[1]` on rising `sck` edges. `io_in[0]`, `io_in[2]` and `io_in[3]` have no effect. During a transfer `io_oe` is 4'b0001, and it is 0 otherwise.
- R5: Payload byte k (0 to 7) is read from, and later replaced by, the response byte in data word k/4 (address 0 or 1) at bits [8*(k%4)+7 : 8*(k%4)]. The response byte that arrives during the opcode is dropped.
- R6: Byte slots at or beyond the payload length keep their previous contents.
- R7: `cs_n` falls 1+H clocks before the first rising `sck` edge and rises 1 clock after the last falling edge. It stays high at least 2 clocks between transfers.
- R8: The divider lives at address 3, bits [7:0], and resets to 2. H = floor(divider/2), with a minimum of 1, and the `sck` period is 2H clocks. `busy` stays high for exactly 4 + 16·H·N clocks, where N is the byte count.
- R9: While `busy` is high, writes to any address are ignored, including a second configuration write.
- R10: `done` is high for exactly one clock when `busy` falls. Ready (read bit 13 at address 2) is set at that point and cleared by the next accepted configuration write. Read bit 12 at address 2 is busy, bits [7:0] are the opcode and bits [11:8] are the effective count.
- R11: After reset, `cs_n` is 1 and `sck`, `io_oe`, `busy`, `done` and ready are 0. Both data words read 0 and the divider reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0/1 data words, 2 configuration, 3 divider |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cs_n | output | 1 | Device chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A table of commands drives the main path with byte counts of 1, 2, 4, 6 and 9, plus the illegal counts 0 and 15. This separates correct length decoding from a count that is off by one or that wraps. Divider settings of 0, 2, 3, 4, 6, 8 and 10 expose an odd divider that is not rounded down, or a divider of zero that is not clamped, through the busy length and the chip-select-to-clock spacing. The device model returns a distinct byte pattern on IO1 and drives its complement on IO0. A design that samples the wrong line or keeps the opcode-time byte therefore leaves wrong data words. Nonzero starting payloads show whether unused byte slots are left untouched.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cs_n,
  output logic        sck,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in,
  output logic        busy,
  output logic        done
);

  localparam int HW = DIV_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP} st_t;

  st_t              st;
  logic [31:0]      word0, word1;
  logic [7:0]       opc_q;
  logic [3:0]       nb_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       byten;
  logic [2:0]       bitn;
  logic [HW-1:0]    cnt;
  logic             sck_q;
  logic [7:0]       txb, rxb;
  logic             gapc;
  logic             ready_q, done_q;

  wire unused_lines = ^{io_in[3:2], io_in[0]};

  wire [HW-1:0] half    = (div_q[DIV_W-1:1] == '0) ? HW'(1) : div_q[DIV_W-1:1];
  wire          tick    = cnt == half - HW'(1);
  wire          wr_ok   = reg_wr && st == S_IDLE;
  wire          cfg_wr  = wr_ok && reg_addr == 2'd2;
  wire [3:0]    len_in  = reg_wdata[11:8];
  wire [3:0]    nb_in   = (len_in == 4'd0 || len_in > 4'd9) ? 4'd1 : len_in;
  wire [3:0]    wb_idx  = byten - 4'd1;

  function automatic logic [7:0] pick(input logic [31:0] a, input logic [31:0] b,
                                      input logic [2:0] k);
    logic [31:0] w;
    w = k[2] ? b : a;
    return w[8*k[1:0] +: 8];
  endfunction

  assign busy   = st != S_IDLE;
  assign done   = done_q;
  assign cs_n   = (st == S_IDLE) || (st == S_GAP);
  assign sck    = sck_q;
  assign io_out = {3'b000, (st == S_LEAD || st == S_SHIFT) ? txb[7] : 1'b0};
  assign io_oe  = {3'b000, !cs_n};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = word0;
      2'd1:    reg_rdata = word1;
      2'd2:    reg_rdata = {18'd0, ready_q, busy, nb_q, opc_q};
      default: reg_rdata = 32'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      word0   <= '0;
      word1   <= '0;
      opc_q   <= '0;
      nb_q    <= 4'd1;
      div_q   <= DIV_W'(DIV_RST);
      byten   <= '0;
      bitn    <= '0;
      cnt     <= '0;
      sck_q   <= 1'b0;
      txb     <= '0;
      rxb     <= '0;
      gapc    <= 1'b0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_ok && reg_addr == 2'd0) word0 <= reg_wdata;
      if (wr_ok && reg_addr == 2'd1) word1 <= reg_wdata;
      if (wr_ok && reg_addr == 2'd3) div_q <= reg_wdata[DIV_W-1:0];
      case (st)
        S_IDLE: if (cfg_wr) begin
          opc_q   <= reg_wdata[7:0];
          nb_q    <= nb_in;
          txb     <= reg_wdata[7:0];
          byten   <= '0;
          bitn    <= '0;
          cnt     <= '0;
          ready_q <= 1'b0;
          st      <= S_LEAD;
        end
        S_LEAD: st <= S_SHIFT;
        S_SHIFT: begin
          if (tick) begin
            cnt   <= '0;
            sck_q <= !sck_q;
            if (!sck_q) begin
              rxb <= {rxb[6:0], io_in[1]};
            end else if (bitn == 3'd7) begin
              bitn <= '0;
              if (byten != 4'd0) begin
                if (wb_idx[2]) word1[8*wb_idx[1:0] +: 8] <= rxb;
                else           word0[8*wb_idx[1:0] +: 8] <= rxb;
              end
              if (byten == nb_q - 4'd1) begin
                st <= S_TRAIL;
              end else begin
                byten <= byten + 4'd1;
                txb   <= pick(word0, word1, byten[2:0]);
              end
            end else begin
              bitn <= bitn + 3'd1;
              txb  <= {txb[6:0], 1'b0};
            end
          end else begin
            cnt <= cnt + HW'(1);
          end
        end
        S_TRAIL: begin
          gapc <= 1'b0;
          st   <= S_GAP;
        end
        default: begin
          gapc <= 1'b1;
          if (gapc) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            ready_q <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r1_start_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (busy && !cs_n));

  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd2) |=> $stable(opc_q));

  a_r9_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(st == S_GAP && gapc)) |=> $stable(div_q));

  a_r7_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck_q);

  a_r8_sck_moves_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> $past(st) == S_SHIFT);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r10_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> done_q);

  a_r3_io0_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q) && st == S_SHIFT) |-> $stable(io_out[0]));

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cs_n, sck, busy, done;
  logic [3:0]  io_out, io_oe, io_in;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n), .sck(sck),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // device model: answer on IO1, complement on IO0, IO2, IO3 to catch a wrong line
  logic [71:0] resp = '0;
  int ptr = 0;
  always @(negedge sck or posedge cs_n) if (cs_n) ptr = 0; else ptr++;
  wire dev_bit = (ptr < 72) ? resp[71-ptr] : 1'b0;
  assign io_in = {~dev_bit, ~dev_bit, dev_bit, ~dev_bit};

  logic [71:0] mosi_cap = '0;
  int sck_rises = 0;
  always @(posedge sck) begin mosi_cap = {mosi_cap[70:0], io_out[0]}; sck_rises++; end

  int cyc = 0, t_csf = 0, t_csr = 0, t_sr = 0, t_sf = 0, gap_min = 1000;
  int busy_cnt = 0, done_cnt = 0, r3_viol = 0, oe_viol = 0, done_viol = 0;
  logic seen_csr = 1'b0, first_pend = 1'b0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_io0 = 1'b0, p_done = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (p_cs && !cs_n) begin
      if (seen_csr && (cyc - t_csr) < gap_min) gap_min = cyc - t_csr;
      t_csf = cyc; first_pend = 1'b1;
    end
    if (!p_cs && cs_n) begin t_csr = cyc; seen_csr = 1'b1; end
    if (!p_sck && sck && first_pend) begin t_sr = cyc; first_pend = 1'b0; end
    if (p_sck && !sck) t_sf = cyc;
    if (p_sck && sck && io_out[0] !== p_io0) r3_viol++;
    if (!cs_n && io_oe !== 4'b0001) oe_viol++;
    if (cs_n && io_oe !== 4'b0000) oe_viol++;
    if (busy) busy_cnt++;
    if (done) begin done_cnt++; if (p_done) done_viol++; end
    p_cs = cs_n; p_sck = sck; p_io0 = io_out[0]; p_done = done;
  end

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [7:0] rb(input logic [7:0] s, input int i);
    return (s ^ 8'(i * 8'h35)) + 8'(i);
  endfunction

  task automatic wait_done(input int d0);
    int guard = 0;
    while (done_cnt == d0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  opc;
    logic [3:0]  len;
    logic [7:0]  div;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h9F, 4'd4,  8'd2,  32'h0000_0000, 32'h0000_0000, 8'h5A},
    '{8'h02, 4'd9,  8'd4,  32'h1122_3344, 32'h5566_7788, 8'hA7},
    '{8'h05, 4'd1,  8'd2,  32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'h3C},
    '{8'h0B, 4'd0,  8'd6,  32'h0102_0304, 32'h0506_0708, 8'h11},
    '{8'h35, 4'd15, 8'd3,  32'hF0F0_F0F0, 32'h0F0F_0F0F, 8'h77},
    '{8'hC7, 4'd6,  8'd0,  32'hDEAD_BEEF, 32'hCAFE_F00D, 8'h81},
    '{8'h66, 4'd2,  8'd10, 32'h8765_4321, 32'h1357_9BDF, 8'hE4}
  };

  task automatic run(input vec_t v);
    int n, h, r0, b0, d0;
    logic [31:0] e0, e1, got;
    logic [71:0] emosi, mask;
    n = (v.len == 0 || v.len > 9) ? 1 : int'(v.len);
    h = int'(v.div) / 2; if (h == 0) h = 1;
    wr(2'd0, v.w0); wr(2'd1, v.w1); wr(2'd3, 32'(v.div));
    resp = '0;
    for (int i = 0; i < n; i++) resp[71-8*i -: 8] = rb(v.seed, i);
    e0 = v.w0; e1 = v.w1; emosi = 72'(v.opc);
    for (int k = 0; k < n - 1; k++) begin
      emosi = (emosi << 8) | 72'(k < 4 ? v.w0[8*k +: 8] : v.w1[8*(k-4) +: 8]);
      if (k < 4) e0[8*k +: 8] = rb(v.seed, k + 1);
      else       e1[8*(k-4) +: 8] = rb(v.seed, k + 1);
    end
    mask = (n == 9) ? '1 : ((72'd1 << (8*n)) - 72'd1);
    r0 = sck_rises; b0 = busy_cnt; d0 = done_cnt;
    wr(2'd2, {20'd0, v.len, v.opc});
    chk(busy === 1'b1 && cs_n === 1'b0, "R1 busy/cs after start", {busy, cs_n}, 2'b10);
    wait_done(d0);
    chk(sck_rises - r0 == 8*n, "R2 sck rising edges", 72'(sck_rises - r0), 72'(8*n));
    chk((mosi_cap & mask) == emosi, "R3 bits on io0", mosi_cap & mask, emosi);
    rd(2'd0, got); chk(got == e0, "R4 R5 R6 word0", 72'(got), 72'(e0));
    rd(2'd1, got); chk(got == e1, "R4 R5 R6 word1", 72'(got), 72'(e1));
    chk(busy_cnt - b0 == 4 + 16*h*n, "R8 busy length", 72'(busy_cnt - b0), 72'(4 + 16*h*n));
    chk(t_sr - t_csf == 1 + h, "R7 cs fall to first rise", 72'(t_sr - t_csf), 72'(1 + h));
    chk(t_csr - t_sf == 1, "R7 last fall to cs rise", 72'(t_csr - t_sf), 72'd1);
    chk(done_cnt - d0 == 1, "R10 one done pulse", 72'(done_cnt - d0), 72'd1);
    rd(2'd2, got);
    chk(got[13:12] == 2'b10 && got[11:0] == {4'(n), v.opc}, "R10 R2 status after done",
        72'(got[13:0]), 72'({2'b10, 4'(n), v.opc}));
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got, e0;
    int b0, d0;
    repeat (3) @(negedge clk);
    chk({cs_n, sck, io_oe, busy, done} === 8'b1000_0000, "R11 pins in reset",
        72'({cs_n, sck, io_oe, busy, done}), 72'b1000_0000);
    rst_n = 1'b1;
    rd(2'd0, got); chk(got == 0, "R11 word0 reset", 72'(got), 0);
    rd(2'd1, got); chk(got == 0, "R11 word1 reset", 72'(got), 0);
    rd(2'd3, got); chk(got == 2, "R11 divider reset", 72'(got), 2);
    rd(2'd2, got); chk(got[13:12] == 2'b00, "R11 ready/busy reset", 72'(got[13:12]), 0);

    foreach (VECS[i]) run(VECS[i]);

    // R9/R10: writes during a transfer are dropped, ready clears on start
    wr(2'd3, 32'd8); wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    resp = '0;
    for (int i = 0; i < 9; i++) resp[71-8*i -: 8] = rb(8'h4D, i);
    b0 = busy_cnt; d0 = done_cnt;
    wr(2'd2, {20'd0, 4'd9, 8'hA1});
    rd(2'd2, got); chk(got[13:12] == 2'b01, "R10 ready cleared by start", 72'(got[13:12]), 72'b01);
    wr(2'd2, {20'd0, 4'd1, 8'h55});
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'd2);
    wait_done(d0);
    rd(2'd2, got); chk(got[11:0] == {4'd9, 8'hA1}, "R9 config write ignored", 72'(got[11:0]), 72'({4'd9, 8'hA1}));
    rd(2'd3, got); chk(got == 8, "R9 divider write ignored", 72'(got), 8);
    e0 = {rb(8'h4D, 4), rb(8'h4D, 3), rb(8'h4D, 2), rb(8'h4D, 1)};
    rd(2'd0, got); chk(got == e0, "R9 data write ignored", 72'(got), 72'(e0));
    chk(busy_cnt - b0 == 4 + 16*4*9, "R9 R8 busy with held divider", 72'(busy_cnt - b0), 72'(580));
    chk(done_cnt - d0 == 1, "R9 single transfer", 72'(done_cnt - d0), 1);

    chk(r3_viol == 0, "R3 io0 stable while sck high", 72'(r3_viol), 0);
    chk(oe_viol == 0, "R4 output enables", 72'(oe_viol), 0);
    chk(gap_min >= 2, "R7 cs high gap", 72'(gap_min), 2);
    chk(done_viol == 0, "R10 done width", 72'(done_viol), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule